// File: doc/BRIEF.md
# Compare-Value Countdown Event Timer

This block is a per-processor deadline timer. It watches a shared 64-bit upcounting system count and raises a level interrupt once that count reaches a programmed deadline. The deadline can be written or read in two forms. One form is an absolute 64-bit compare value. The other is a relative 32-bit view that reads as the number of ticks still remaining, so it behaves like a down-counter.

A small control word holds an enable bit, a mask bit and a read-only status bit. Software normally programs only one of the two deadline views, because either one fully sets the deadline. The interrupt output is meant to feed an interrupt controller as a private per-processor line.

Register access uses a single-cycle write strobe with a 2-bit register select. Reads are combinational from the same select.

Top module: `cmp_event_timer`

## Requirements
- R1: After reset, the enable bit and the mask bit are 0, the compare value is 0, the control word reads 0 and `irq_o` is low.
- R2: The register select encodes control as 0, compare value as 1 and timer value as 2. Select 3 reads as all zeros, and a write to select 3 changes neither the control word nor the compare value.
- R3: In the control word, bit 0 is enable and bit 1 is mask. Both are written from `wdata_i` and read back in place. Control bits 31..3 always read 0, and `rdata_o[63:32]` is 0 whenever the control word is selected.
- R4: Control bit 2 is a read-only status. It reads 1 exactly when enable is 1 and the condition count >= compare holds. Writes to bit 2 are ignored.
- R5: A write to select 1 loads all 64 bits of `wdata_i` into the compare value, taking effect on the clock edge of the write.
- R6: A read of select 2 returns the low 32 bits of (compare value − count), zero-extended to 64 bits.
- R7: A write to select 2 sets the compare value to count_i plus `wdata_i[31:0]` sign-extended to 64 bits, modulo 2^64, using the count present at that write edge.
- R8: `irq_o` equals enable AND condition AND NOT mask, where the condition is count >= compare. It is a level that follows `count_i` combinationally.
- R9: The condition is an unsigned 64-bit comparison, including near the all-ones count and around the 2^63 boundary.
- R10: An asserted `irq_o` drops on the clock edge of a write that clears enable, sets mask, or moves the compare value above the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| count_i | input | 64 | Shared system count value |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select (0 control, 1 compare, 2 timer value, 3 none) |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for the selected register |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions assume that `sel_i`, `wr_en_i`, `wdata_i` and `count_i` are settled at each rising edge. They also assume that a timer-value write is judged against the count present at that same edge. The bench meets both conditions by changing every input only on falling edges. It holds the count steady across each write and samples outputs shortly after the falling edge. It drives the count directly, not as a free-running counter, so the unsigned boundaries can be swept one tick at a time around each chosen compare value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CVAL = 2'd1,
    SEL_TVAL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MASK_BIT = 1;
  localparam int unsigned CTRL_STAT_BIT = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned TV_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             en_o,
  output logic             mask_o,
  output logic [CNT_W-1:0] cval_o
);
  localparam int unsigned EXT_W = CNT_W - TV_W;

  logic [CNT_W-1:0] tv_ext;
  logic             wr_ctrl, wr_cval, wr_tval;

  assign tv_ext  = {{EXT_W{wdata_i[TV_W-1]}}, wdata_i[TV_W-1:0]};
  assign wr_ctrl = wr_en_i && (sel_i == SEL_CTRL);
  assign wr_cval = wr_en_i && (sel_i == SEL_CVAL);
  assign wr_tval = wr_en_i && (sel_i == SEL_TVAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      mask_o <= 1'b0;
    end else if (wr_ctrl) begin
      en_o   <= wdata_i[CTRL_EN_BIT];
      mask_o <= wdata_i[CTRL_MASK_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cval_o <= '0;
    else if (wr_cval) cval_o <= wdata_i;
    else if (wr_tval) cval_o <= count_i + tv_ext;
  end

  p_cval_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_cval || wr_tval) |=> $stable(cval_o));
  p_cval_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cval |=> cval_o == $past(wdata_i));
  p_tval_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tval |=> cval_o == $past(count_i) + $past(tv_ext));
  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(en_o) && $stable(mask_o));
endmodule

// File: rtl/tmr_cond.sv
module tmr_cond #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             en_i,
  input  logic             mask_i,
  input  logic [CNT_W-1:0] cval_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             status_o,
  output logic             irq_o
);
  logic [CNT_W:0] diff;
  logic           met;

  // borrow-out of count - compare clear means count >= compare (unsigned)
  assign diff     = {1'b0, count_i} - {1'b0, cval_i};
  assign met      = ~diff[CNT_W];
  assign status_o = en_i & met;
  assign irq_o    = status_o & ~mask_i;
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned TV_W   = 32,
  parameter int unsigned CTRL_W = 32
) (
  input  reg_sel_e         sel_i,
  input  logic             en_i,
  input  logic             mask_i,
  input  logic             status_i,
  input  logic [CNT_W-1:0] cval_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] rdata_o
);
  logic [CTRL_W-1:0] ctrl_word;
  logic [CNT_W-1:0]  remain;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT]   = en_i;
    ctrl_word[CTRL_MASK_BIT] = mask_i;
    ctrl_word[CTRL_STAT_BIT] = status_i;
  end

  assign remain = cval_i - count_i;

  always_comb begin
    unique case (sel_i)
      SEL_CTRL: rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_word};
      SEL_CVAL: rdata_o = cval_i;
      SEL_TVAL: rdata_o = {{(CNT_W-TV_W){1'b0}}, remain[TV_W-1:0]};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned TV_W   = 32,
  parameter int unsigned CTRL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_en_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  reg_sel_e         sel;
  logic             en, mask, status;
  logic [CNT_W-1:0] cval;

  assign sel = reg_sel_e'(sel_i);

  tmr_regs #(.CNT_W(CNT_W), .TV_W(TV_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .sel_i  (sel),
    .wdata_i(wdata_i),
    .count_i(count_i),
    .en_o   (en),
    .mask_o (mask),
    .cval_o (cval)
  );

  tmr_cond #(.CNT_W(CNT_W)) u_cond (
    .en_i    (en),
    .mask_i  (mask),
    .cval_i  (cval),
    .count_i (count_i),
    .status_o(status),
    .irq_o   (irq_o)
  );

  tmr_rdmux #(.CNT_W(CNT_W), .TV_W(TV_W), .CTRL_W(CTRL_W)) u_rdmux (
    .sel_i   (sel),
    .en_i    (en),
    .mask_i  (mask),
    .status_i(status),
    .cval_i  (cval),
    .count_i (count_i),
    .rdata_o (rdata_o)
  );

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en && !mask && count_i >= cval));
  p_irq_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_CTRL && (!wdata_i[CTRL_EN_BIT] || wdata_i[CTRL_MASK_BIT]))
    |=> !irq_o);
  p_stat_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_CTRL && !en) |-> !rdata_o[CTRL_STAT_BIT]);
  p_none_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE) |-> rdata_o == '0);
  p_ctrl_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_CTRL) |-> rdata_o[CNT_W-1:CTRL_STAT_BIT+1] == '0);
endmodule

// File: tb/cmp_event_timer_test.sv
`timescale 1ns/1ps
module cmp_event_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_event_timer uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .count_i(count),
    .wr_en_i(wr_en),
    .sel_i  (sel),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] d);
    sel = s;
    #1;
    d = rdata;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] bases [4];
    bases[0] = 64'h0;
    bases[1] = 64'd1000;
    bases[2] = 64'hFFFF_FFFF_FFFF_FFF0;
    bases[3] = 64'h8000_0000_0000_0000;

    count = 64'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 64'd0);
    rd(2'd1, v); chk("R1 cval", v, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);

    // R3 control bits, status folded in (cval 0 <= count 5)
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0, v); chk("R3 ctrl all-ones", v, 64'd7);
    wr(2'd0, 64'd0);
    rd(2'd0, v); chk("R3 ctrl cleared", v, 64'd0);

    // R4 write to status bit ignored
    wr(2'd0, 64'd4);
    rd(2'd0, v); chk("R4 status write ignored", v, 64'd0);
    chk("R4 irq off", {63'd0, irq}, 64'd0);

    // R5 full compare load
    wr(2'd1, 64'h0123_4567_89AB_CDEF);
    rd(2'd1, v); chk("R5 cval", v, 64'h0123_4567_89AB_CDEF);

    // R2 select 3
    wr(2'd0, 64'd2);
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd3, v); chk("R2 none reads zero", v, 64'd0);
    rd(2'd1, v); chk("R2 cval untouched", v, 64'h0123_4567_89AB_CDEF);
    rd(2'd0, v); chk("R2 ctrl untouched", v, 64'd2);

    // R4 R6 R8 R9 sweep
    for (int b = 0; b < 4; b++) begin
      wr(2'd1, bases[b]);
      for (int c = 0; c < 4; c++) begin
        wr(2'd0, 64'(c));
        for (int d = -3; d <= 3; d++) begin
          logic [63:0] cv, cn, diff;
          logic met, en, mk;
          cv = bases[b];
          cn = cv + 64'(signed'(d));
          count = cn;
          met = (cn >= cv);
          en = c[0]; mk = c[1];
          diff = cv - cn;
          #1;
          chk("R8 R9 irq", {63'd0, irq}, {63'd0, en & met & ~mk});
          rd(2'd0, v);
          chk("R4 status", v, {61'd0, en & met, mk, en});
          rd(2'd2, v);
          chk("R6 tval read", v, {32'd0, diff[31:0]});
        end
      end
    end

    // R7 relative writes
    count = 64'd100;
    wr(2'd2, 64'h0000_0000_FFFF_FFF6);
    rd(2'd1, v); chk("R7 negative tval", v, 64'd90);
    wr(2'd2, 64'hDEAD_BEEF_0000_0032);
    rd(2'd1, v); chk("R7 positive tval", v, 64'd150);
    count = 64'hFFFF_FFFF_FFFF_FFFB;
    wr(2'd2, 64'd10);
    rd(2'd1, v); chk("R7 wrap", v, 64'd5);
    rd(2'd2, v); chk("R6 after tval write", v, 64'd10);

    // R10 deassertion paths
    count = 64'd500;
    wr(2'd1, 64'd400);
    wr(2'd0, 64'd1);
    chk("R10 irq set", {63'd0, irq}, 64'd1);
    wr(2'd1, 64'd600);
    chk("R10 cval move", {63'd0, irq}, 64'd0);
    wr(2'd1, 64'd400);
    chk("R10 irq again", {63'd0, irq}, 64'd1);
    wr(2'd0, 64'd3);
    chk("R10 mask set", {63'd0, irq}, 64'd0);
    wr(2'd0, 64'd1);
    chk("R10 irq unmasked", {63'd0, irq}, 64'd1);
    wr(2'd0, 64'd0);
    chk("R10 enable clear", {63'd0, irq}, 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule